// File: doc/BRIEF.md
# Row-Stationary 2D Convolution Array

This block computes one 2D convolution of a small filter over a small input feature map. The work is split into 1D row convolutions. A grid of processing elements does them all at once: one grid row per filter row and one grid column per output row. Each element keeps a private copy of one filter row and one input row in local registers. It walks a window across the input row and leaves one row of partial sums in its own accumulator registers.

Filter rows reach every element of their grid row. Input rows reach the elements on an anti-diagonal, so the input row used by element (r, e) is row r + e. When the multiply phase ends, the partial-sum rows are added up each grid column, one grid row per cycle. The top element of each column then holds a finished output row, and the rows are streamed out one per cycle.

The host loads the filter and the input map one element per cycle, then pulses a start strobe. All loaded values stay resident, so a later start without reloading computes the same result again.

Top module: `rs_conv_array`

## Requirements
- R1: While reset is held and after it is released, out_valid and done stay low until a start is accepted.
- R2: A filter element written while idle goes to filter position (k / FCOLS, k mod FCOLS), where k counts filter writes since the last accepted start. Every element in that grid row uses the same value, for all output rows.
- R3: An input element written while idle goes to input position (k / IWID, k mod IWID), where k counts input writes since the last accepted start. Input row h feeds exactly the elements with r + e = h.
- R4: Output element x of row e equals the sum over r and s of filter[r][s] * input[e+r][x+s]. Operands are signed 8-bit and the sum is signed 24-bit. Element x sits at out_row bits [24x+23 : 24x].
- R5: Counting clock edges from the edge that accepts start as 0, out_valid is high for the cycles after edges Q*FCOLS+FROWS-1 through Q*FCOLS+FROWS+OROWS-2, where Q = IWID-FCOLS+1. out_idx equals 0, 1, ... OROWS-1 in that order.
- R6: done is high for exactly one cycle, directly after the cycle of the last output row, and never together with out_valid.
- R7: start, wgt_valid and ifm_valid are ignored from the accepting edge until done has been shown. They change neither the running result nor the stored data.
- R8: Writes beyond FROWS*FCOLS filter elements or beyond (FROWS+OROWS-1)*IWID input elements are ignored. An accepted start rewinds both write counts to element 0. Start has priority over a write in the same cycle.
- R9: A start accepted without any new writes uses the resident filter and input data and yields the same rows as before.
- R10: Extreme operands (all -128, or -128 and 127 mixed) give exact 24-bit sums with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a computation when idle |
| wgt_valid | input | 1 | Filter element write strobe |
| wgt_data | input | 8 | Signed filter element |
| ifm_valid | input | 1 | Input element write strobe |
| ifm_data | input | 8 | Signed input element |
| out_valid | output | 1 | Output row strobe |
| out_idx | output | 2 | Index of the output row being shown |
| out_row | output | 72 | Output row, element x at bits 24x and up |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
If an element's local filter or input copy lands in the wrong place, or its window pointer drifts, the corrupted partial sums stay hidden until the column reduction. They then show up as wrong values in one specific output row, Q*FCOLS+FROWS-1 cycles after start at the earliest. If the column chain adds the wrong neighbour, every row changes at once. A sequencing fault moves out_valid or done off their fixed cycle. The reference model checks both timing and data every cycle, so a fault is reported at its first visible cycle. Broadcast faults are exposed by one-row filters and diagonal faults by row-constant inputs.

// File: rtl/rs_conv_array.sv
module rs_conv_array #(
  parameter int DW    = 8,
  parameter int PW    = 24,
  parameter int FROWS = 3,
  parameter int FCOLS = 3,
  parameter int IWID  = 5,
  parameter int OROWS = 3,
  localparam int OQ   = IWID - FCOLS + 1,
  localparam int EW   = (OROWS > 1) ? $clog2(OROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wgt_valid,
  input  logic signed [DW-1:0] wgt_data,
  input  logic                 ifm_valid,
  input  logic signed [DW-1:0] ifm_data,
  output logic                 out_valid,
  output logic [EW-1:0]        out_idx,
  output logic [OQ*PW-1:0]     out_row,
  output logic                 done
);
  localparam int IROWS = FROWS + OROWS - 1;
  localparam int XW = (OQ > 1) ? $clog2(OQ) : 1;
  localparam int KW = (FCOLS > 1) ? $clog2(FCOLS) : 1;
  localparam int CW = (IWID > 1) ? $clog2(IWID) : 1;
  localparam int RW = (FROWS > 1) ? $clog2(FROWS) : 1;
  localparam int HW = (IROWS > 1) ? $clog2(IROWS) : 1;
  localparam int AW = (FROWS > 2) ? $clog2(FROWS - 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_MAC, S_ACC, S_EMIT, S_DONE} st_t;
  st_t st;

  logic [XW-1:0] xcnt;
  logic [KW-1:0] kcnt;
  logic [AW-1:0] acnt;
  logic [EW-1:0] ecnt;
  logic [RW-1:0] wr;
  logic [KW-1:0] wc;
  logic [HW-1:0] ir;
  logic [CW-1:0] ic;
  logic          wfull, ifull;

  logic signed [DW-1:0] wrf [FROWS][OROWS][FCOLS];
  logic signed [DW-1:0] irf [FROWS][OROWS][IWID];
  logic signed [PW-1:0] ps  [FROWS][OROWS][OQ];

  wire idle = (st == S_IDLE);
  wire clr  = idle && start;
  wire wld  = idle && !start && wgt_valid && !wfull;
  wire ild  = idle && !start && ifm_valid && !ifull;
  wire [CW-1:0] pos = CW'(xcnt) + CW'(kcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      xcnt <= '0; kcnt <= '0; acnt <= '0; ecnt <= '0;
      wr <= '0; wc <= '0; ir <= '0; ic <= '0;
      wfull <= 1'b0; ifull <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            st <= S_MAC;
            xcnt <= '0; kcnt <= '0;
            wr <= '0; wc <= '0; ir <= '0; ic <= '0;
            wfull <= 1'b0; ifull <= 1'b0;
          end else begin
            if (wld) begin
              if (wc == KW'(FCOLS - 1)) begin
                wc <= '0;
                if (wr == RW'(FROWS - 1)) wfull <= 1'b1;
                else wr <= wr + RW'(1);
              end else wc <= wc + KW'(1);
            end
            if (ild) begin
              if (ic == CW'(IWID - 1)) begin
                ic <= '0;
                if (ir == HW'(IROWS - 1)) ifull <= 1'b1;
                else ir <= ir + HW'(1);
              end else ic <= ic + CW'(1);
            end
          end
        end
        S_MAC: begin
          if (kcnt == KW'(FCOLS - 1)) begin
            kcnt <= '0;
            if (xcnt == XW'(OQ - 1)) begin
              xcnt <= '0;
              acnt <= '0;
              ecnt <= '0;
              st <= (FROWS > 1) ? S_ACC : S_EMIT;
            end else xcnt <= xcnt + XW'(1);
          end else kcnt <= kcnt + KW'(1);
        end
        S_ACC: begin
          if (acnt == AW'(FROWS - 2)) st <= S_EMIT;
          else acnt <= acnt + AW'(1);
        end
        S_EMIT: begin
          if (ecnt == EW'(OROWS - 1)) st <= S_DONE;
          else ecnt <= ecnt + EW'(1);
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < FROWS; r++) begin
      for (int e = 0; e < OROWS; e++) begin
        if (wld && wr == RW'(r)) wrf[r][e][wc] <= wgt_data;
        if (ild && ir == HW'(r + e)) irf[r][e][ic] <= ifm_data;
        if (clr) begin
          for (int x = 0; x < OQ; x++) ps[r][e][x] <= '0;
        end else if (st == S_MAC) begin
          ps[r][e][xcnt] <= ps[r][e][xcnt] +
            PW'($signed((2*DW)'(wrf[r][e][kcnt])) * $signed((2*DW)'(irf[r][e][pos])));
        end else if (st == S_ACC && r < FROWS - 1 && acnt == AW'(FROWS - 2 - r)) begin
          for (int x = 0; x < OQ; x++)
            ps[r][e][x] <= ps[r][e][x] + ps[(r < FROWS - 1) ? r + 1 : r][e][x];
        end
      end
    end
  end

  for (genvar x = 0; x < OQ; x++) begin : g_out
    assign out_row[x*PW +: PW] = ps[0][ecnt][x];
  end

  assign out_valid = (st == S_EMIT);
  assign out_idx   = ecnt;
  assign done      = (st == S_DONE);

endmodule

module rs_conv_array_chk #(
  parameter int FROWS = 3,
  parameter int FCOLS = 3,
  parameter int IWID  = 5,
  parameter int OROWS = 3,
  localparam int EW   = (OROWS > 1) ? $clog2(OROWS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_valid,
  input logic [EW-1:0] out_idx,
  input logic          done
);
  localparam int LAT = (IWID - FCOLS + 1) * FCOLS + FROWS - 1;

  logic run;
  int   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= 0;
    end else if (!run) begin
      if (start) begin
        run <= 1'b1;
        cnt <= 0;
      end
    end else if (done) run <= 1'b0;
    else cnt <= cnt + 1;
  end

  AST_ROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> run && cnt >= LAT && cnt < LAT + OROWS); // R5
  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_idx == EW'(cnt - LAT)); // R5
  AST_DONE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run && cnt == LAT + OROWS); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !out_valid && !done); // R1
endmodule

bind rs_conv_array rs_conv_array_chk #(
  .FROWS(FROWS), .FCOLS(FCOLS), .IWID(IWID), .OROWS(OROWS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .out_valid(out_valid), .out_idx(out_idx), .done(done)
);

// File: tb/test_rs_conv_array.sv
`timescale 1ns/1ps
module test_rs_conv_array;
  localparam int FR = 3, FC = 3, IW = 5, OR = 3;
  localparam int IR = FR + OR - 1;
  localparam int Q = IW - FC + 1;
  localparam int LAT = Q * FC + FR - 1;
  localparam int LAST = LAT + OR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wgt_valid = 1'b0;
  logic signed [7:0] wgt_data = '0;
  logic ifm_valid = 1'b0;
  logic signed [7:0] ifm_data = '0;
  logic out_valid;
  logic [1:0] out_idx;
  logic [Q*24-1:0] out_row;
  logic done;

  rs_conv_array i_rs_conv_array (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wgt_valid(wgt_valid), .wgt_data(wgt_data),
    .ifm_valid(ifm_valid), .ifm_data(ifm_data),
    .out_valid(out_valid), .out_idx(out_idx), .out_row(out_row), .done(done)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  string tag = "R1";

  int mw [FR][FC];
  int mi [IR][IW];
  int ex [OR][Q];
  int mwc = 0, mic = 0, n = 0;
  bit busy = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural reference: load counters, busy window and 2D convolution
  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0; n = 0; mwc = 0; mic = 0;
    end else if (busy) begin
      if (n == LAST) busy = 0;
      else n++;
    end else if (start) begin
      busy = 1; n = 0; mwc = 0; mic = 0;
      for (int e = 0; e < OR; e++)
        for (int x = 0; x < Q; x++) begin
          ex[e][x] = 0;
          for (int r = 0; r < FR; r++)
            for (int s = 0; s < FC; s++)
              ex[e][x] += mw[r][s] * mi[e + r][x + s];
        end
    end else begin
      if (wgt_valid && mwc < FR * FC) begin
        mw[mwc / FC][mwc % FC] = int'(wgt_data);
        mwc++;
      end
      if (ifm_valid && mic < IR * IW) begin
        mi[mic / IW][mic % IW] = int'(ifm_data);
        mic++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev, ed;
      ev = busy && n >= LAT && n < LAT + OR;
      ed = busy && n == LAST;
      chk(out_valid == ev, "R5", "out_valid", int'(out_valid), int'(ev));
      chk(done == ed, "R6", "done", int'(done), int'(ed));
      if (ev && out_valid) begin
        chk(int'(out_idx) == n - LAT, "R5", "out_idx", int'(out_idx), n - LAT);
        for (int x = 0; x < Q; x++) begin
          logic signed [23:0] g;
          g = out_row[x*24 +: 24];
          chk(int'(g) == ex[n - LAT][x], tag, $sformatf("row %0d elem %0d", n - LAT, x),
              int'(g), ex[n - LAT][x]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 50000);
      report();
    end
  end

  task automatic put_w(int v);
    @(negedge clk); wgt_valid = 1'b1; wgt_data = 8'(v);
  endtask

  task automatic put_i(int v);
    @(negedge clk); ifm_valid = 1'b1; ifm_data = 8'(v);
  endtask

  task automatic quiet();
    @(negedge clk); wgt_valid = 1'b0; ifm_valid = 1'b0; start = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); wgt_valid = 1'b0; ifm_valid = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int rnd();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  initial begin
    // R1: quiet outputs in and after reset
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1", "in reset valid|done", int'(out_valid | done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1", "after reset valid|done", int'(out_valid | done), 0);

    // R4: random data
    for (int t = 0; t < 4; t++) begin
      tag = "R4";
      for (int k = 0; k < FR * FC; k++) put_w(rnd());
      for (int k = 0; k < IR * IW; k++) put_i(rnd());
      go();
    end

    // R2: one live filter row, the broadcast reaches every output row
    for (int live = 0; live < FR; live++) begin
      tag = "R2";
      for (int k = 0; k < FR * FC; k++) put_w((k / FC == live) ? (k % FC) + 2 : 0);
      for (int k = 0; k < IR * IW; k++) put_i(rnd());
      go();
    end

    // R3: row-constant input exposes diagonal delivery
    tag = "R3";
    for (int k = 0; k < FR * FC; k++) put_w(rnd());
    for (int k = 0; k < IR * IW; k++) put_i((k / IW + 1) * 7);
    go();

    // R10: extremes
    tag = "R10";
    for (int k = 0; k < FR * FC; k++) put_w(-128);
    for (int k = 0; k < IR * IW; k++) put_i(-128);
    go();
    for (int k = 0; k < FR * FC; k++) put_w(k[0] ? 127 : -128);
    for (int k = 0; k < IR * IW; k++) put_i(k[0] ? -128 : 127);
    go();

    // R7: traffic during a run is ignored
    tag = "R7";
    for (int k = 0; k < FR * FC; k++) put_w(rnd());
    for (int k = 0; k < IR * IW; k++) put_i(rnd());
    @(negedge clk); wgt_valid = 1'b0; ifm_valid = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      start = 1'b1; wgt_valid = 1'b1; wgt_data = 8'(rnd());
      ifm_valid = 1'b1; ifm_data = 8'(rnd());
    end
    quiet();
    while (busy) @(negedge clk);
    @(negedge clk);

    // R9: restart on resident data
    tag = "R9";
    go();

    // R8: overflow writes dropped, start rewinds the counts
    tag = "R8";
    for (int k = 0; k < FR * FC; k++) put_w(rnd());
    for (int k = 0; k < IR * IW; k++) put_i(rnd());
    for (int k = 0; k < 4; k++) begin put_w(99); put_i(-99); end
    go();
    for (int k = 0; k < 3; k++) put_w(-5 - k);
    for (int k = 0; k < 4; k++) put_i(11 + k);
    go();

    repeat (4) @(negedge clk);
    chk(!out_valid && !done, "R1", "final idle valid|done", int'(out_valid | done), 0);
    report();
  end
endmodule